// File: doc/BRIEF.md
# Neighbour-Hop Lane Shuffle Network

This block exchanges data words among the SIMD lanes of a clustered datapath without any crossbar. Each lane owns two words of a vector of 2·LANES elements: lane `l` holds element `l` in its low slot and element `l+LANES` in its high slot. Data leaves a lane only through registered links to its two adjacent lanes. One chain of registers carries every lane's word pair one lane to the right per cycle, and a second chain carries it one lane to the left. Each lane chooses which passing pair, and which slot of it, to capture. The select and capture logic depends only on the operation, the lane index and a shared step counter. Wiring therefore grows linearly with the lane count.

A one-cycle `start` samples the opcode, the source lane and the whole input vector. Three operations are available. Pass-through returns the vector unchanged. Broadcast copies one lane's word pair into every lane. Odd-even grouping places the even-indexed elements in the first half of the result and the odd-indexed elements in the second half. Every operation takes the same fixed number of cycles. The result appears on the registered output in the cycle of a one-cycle `done` pulse, and it stays there until the next completion.

Feeding the grouped vector back in as the next input rotates each element's index right by one bit per pass. For a row-major matrix with Q columns, log2(Q) passes give its transpose.

Top module: `lane_shuffle_net`

## Requirements
- R1: While reset is high and after it falls, with no operation run, `done` is 0 and `out_data` is all zeros.
- R2: Element `e` (0 to 2·LANES-1) of `in_data` and of `out_data` occupies bits `[e*WIDTH +: WIDTH]`. Lane `e mod LANES` holds it, in slot `e / LANES`.
- R3: Opcode 0 (pass) and opcode 3 (alternate pass) produce `out_data` equal to the sampled `in_data`.
- R4: Opcode 1 (broadcast) with source lane `s` produces output element `e` equal to input element `s + LANES*(e / LANES)`, so every lane receives lane `s`'s pair.
- R5: Opcode 2 (grouping) produces output element `j` equal to input element `2j` for `j < LANES`, and equal to input element `2(j-LANES)+1` for `j >= LANES`.
- R6: Take `start` sampled at clock edge T. `done` is then high for exactly one cycle, after edge T+LATENCY (default 2·LANES, which is 8 for 4 lanes). `out_data` takes the new result at that same edge.
- R7: A `start` that arrives while an operation is in progress is ignored. It produces no extra `done`, and the running operation's result is unaffected.
- R8: `out_data` holds its value between completions, whatever happens on `in_data`, `op` and `src_lane`.
- R9: Two grouping passes on 4 lanes turn a 2×4 row-major matrix (element `4r+c`) into its 4×2 transpose (element `2c+r`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; sampled only when idle |
| op | input | 2 | Operation code: 0 pass, 1 broadcast, 2 grouping, 3 pass |
| src_lane | input | log2(LANES) | Source lane for broadcast |
| in_data | input | 2·LANES·WIDTH | Input vector, element e at bits e·WIDTH |
| out_data | output | 2·LANES·WIDTH | Registered result vector, same layout |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with LANES=4, WIDTH=16 and the default LATENCY of 8. With these values, every hop distance from 0 to 3 is used in both chain directions, and broadcast can be run from each end lane and from the inner lanes. The same values allow the 8-element grouping pattern and a two-pass transpose of a 2×4 matrix to be checked exactly against a software model. The short latency also lets a second start be placed inside a busy window within a few cycles.

// File: rtl/lsn_pkg.sv
package lsn_pkg;

  typedef enum logic [1:0] {
    OP_PASS     = 2'd0,
    OP_BCAST    = 2'd1,
    OP_GROUP    = 2'd2,
    OP_PASS_ALT = 2'd3
  } lsn_op_e;

endpackage

// File: rtl/lsn_ctrl.sv
module lsn_ctrl #(
  parameter int LATENCY = 8,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output logic          shift,
  output logic          commit,
  output logic          busy,
  output logic [CW-1:0] step,
  output logic          done
);

  assign load   = start && !busy;
  assign shift  = busy;
  assign commit = busy && (step == CW'(LATENCY - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= commit;
      if (load) begin
        busy <= 1'b1;
        step <= '0;
      end else if (commit) begin
        busy <= 1'b0;
      end else if (busy) begin
        step <= step + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R6

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !commit) |=> (busy && step == $past(step) + 1'b1)); // R7

endmodule

// File: rtl/lsn_lane.sv
module lsn_lane
  import lsn_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WIDTH = 16,
  parameter int IDX   = 0,
  parameter int CW    = 3,
  parameter int LW    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               shift,
  input  logic [CW-1:0]      step,
  input  lsn_op_e            op,
  input  logic [LW-1:0]      src,
  input  logic [2*WIDTH-1:0] own_pair,
  input  logic [2*WIDTH-1:0] from_lower,
  input  logic [2*WIDTH-1:0] from_upper,
  output logic [2*WIDTH-1:0] rgt_q,
  output logic [2*WIDTH-1:0] lft_q,
  output logic [2*WIDTH-1:0] cap_q
);

  localparam int G_LO    = 2 * IDX;
  localparam int G_HI    = 2 * IDX + 1;
  localparam int LANE_LO = G_LO % LANES;
  localparam int LANE_HI = G_HI % LANES;
  localparam int SLOT_LO = G_LO / LANES;
  localparam int SLOT_HI = G_HI / LANES;
  localparam int DIST_LO = LANE_LO - IDX;
  localparam int DIST_HI = LANE_HI - IDX;

  logic [WIDTH-1:0] nxt_lo, nxt_hi;

  always_comb begin
    int s;
    int d_bc;
    s      = int'(step);
    d_bc   = int'(src) - IDX;
    nxt_lo = cap_q[WIDTH-1:0];
    nxt_hi = cap_q[2*WIDTH-1:WIDTH];
    case (op)
      OP_BCAST: begin
        if (d_bc >= 0 && s == d_bc) begin
          nxt_lo = lft_q[WIDTH-1:0];
          nxt_hi = lft_q[2*WIDTH-1:WIDTH];
        end else if (d_bc < 0 && s == -d_bc) begin
          nxt_lo = rgt_q[WIDTH-1:0];
          nxt_hi = rgt_q[2*WIDTH-1:WIDTH];
        end
      end
      OP_GROUP: begin
        if (DIST_LO >= 0 && s == DIST_LO)
          nxt_lo = lft_q[SLOT_LO*WIDTH +: WIDTH];
        else if (DIST_LO < 0 && s == -DIST_LO)
          nxt_lo = rgt_q[SLOT_LO*WIDTH +: WIDTH];
        if (DIST_HI >= 0 && s == DIST_HI)
          nxt_hi = lft_q[SLOT_HI*WIDTH +: WIDTH];
        else if (DIST_HI < 0 && s == -DIST_HI)
          nxt_hi = rgt_q[SLOT_HI*WIDTH +: WIDTH];
      end
      default: begin
        if (s == 0) begin
          nxt_lo = lft_q[WIDTH-1:0];
          nxt_hi = lft_q[2*WIDTH-1:WIDTH];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rgt_q <= '0;
      lft_q <= '0;
      cap_q <= '0;
    end else if (load) begin
      rgt_q <= own_pair;
      lft_q <= own_pair;
    end else if (shift) begin
      rgt_q <= from_lower;
      lft_q <= from_upper;
      cap_q <= {nxt_hi, nxt_lo};
    end
  end

  AST_CAP_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(cap_q)); // R8

endmodule

// File: rtl/lane_shuffle_net.sv
module lane_shuffle_net
  import lsn_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int WIDTH   = 16,
  parameter int LATENCY = 2 * LANES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [1:0]                 op,
  input  logic [$clog2(LANES)-1:0]   src_lane,
  input  logic [2*LANES*WIDTH-1:0]   in_data,
  output logic [2*LANES*WIDTH-1:0]   out_data,
  output logic                       done
);

  localparam int LW = $clog2(LANES);
  localparam int CW = $clog2(LATENCY);
  localparam int PW = 2 * WIDTH;

  logic          load, shift, commit, busy;
  logic [CW-1:0] step;
  lsn_op_e       op_q;
  logic [LW-1:0] src_q;

  logic [PW-1:0] rgt [LANES];
  logic [PW-1:0] lft [LANES];
  logic [PW-1:0] cap [LANES];
  logic [PW-1:0] lo_in [LANES];
  logic [PW-1:0] hi_in [LANES];

  lsn_ctrl #(.LATENCY(LATENCY), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load), .shift(shift),
    .commit(commit), .busy(busy), .step(step), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_PASS;
      src_q <= '0;
    end else if (load) begin
      op_q  <= lsn_op_e'(op);
      src_q <= src_lane;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign lo_in[g] = '0;
    end else begin : g_mid_lo
      assign lo_in[g] = rgt[g-1];
    end
    if (g == LANES - 1) begin : g_last
      assign hi_in[g] = '0;
    end else begin : g_mid_hi
      assign hi_in[g] = lft[g+1];
    end

    lsn_lane #(.LANES(LANES), .WIDTH(WIDTH), .IDX(g), .CW(CW), .LW(LW)) u_lane (
      .clk(clk), .rst(rst), .load(load), .shift(shift), .step(step),
      .op(op_q), .src(src_q),
      .own_pair({in_data[(g+LANES)*WIDTH +: WIDTH], in_data[g*WIDTH +: WIDTH]}),
      .from_lower(lo_in[g]), .from_upper(hi_in[g]),
      .rgt_q(rgt[g]), .lft_q(lft[g]), .cap_q(cap[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
    end else if (commit) begin
      for (int l = 0; l < LANES; l++) begin
        out_data[l*WIDTH +: WIDTH]         <= cap[l][WIDTH-1:0];
        out_data[(l+LANES)*WIDTH +: WIDTH] <= cap[l][PW-1:WIDTH];
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(out_data)); // R8

  AST_OUT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_data) |-> done); // R6

endmodule

// File: tb/sim_lane_shuffle_net.sv
module sim_lane_shuffle_net;

  localparam int C   = 4;
  localparam int W   = 16;
  localparam int LAT = 2 * C;
  localparam int N   = 2 * C;
  localparam int DW  = N * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [1:0]    src = 2'd0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] out_data;
  logic          done;

  always #4 clk = ~clk;

  lane_shuffle_net #(.LANES(C), .WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .src_lane(src),
    .in_data(in_data), .out_data(out_data), .done(done)
  );

  int cyc = 0;
  int nrun = 0;
  int nfail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] exp_q[$];
  int            due_q[$];
  string         tag_q[$];

  function automatic logic [DW-1:0] model(input logic [1:0] o, input int s,
                                          input logic [DW-1:0] x);
    logic [DW-1:0] y;
    y = x;
    if (o == 2'd1) begin
      for (int e = 0; e < N; e++) y[e*W +: W] = x[(s + C*(e/C))*W +: W];
    end else if (o == 2'd2) begin
      for (int j = 0; j < C; j++) begin
        y[j*W +: W]     = x[(2*j)*W +: W];
        y[(j+C)*W +: W] = x[(2*j+1)*W +: W];
      end
    end
    return y;
  endfunction

  function automatic logic [DW-1:0] rnd_vec();
    logic [DW-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = W'($urandom);
    return v;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] expv);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every completion pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected done", DW'(1), DW'(0));
      end else begin
        logic [DW-1:0] e;
        int            d;
        string         t;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        t = tag_q.pop_front();
        check(out_data === e, t, out_data, e);
        check(cyc == d, {t, " R6 latency"}, DW'(cyc), DW'(d));
      end
    end
  end

  // Driver: launches one operation and records its expected result
  task automatic issue(input logic [1:0] o, input int s, input logic [DW-1:0] x,
                       input string tag);
    @(negedge clk);
    start = 1'b1;
    op    = o;
    src   = 2'(s);
    in_data = x;
    exp_q.push_back(model(o, s, x));
    due_q.push_back(cyc + LAT + 1);
    tag_q.push_back(tag);
    @(negedge clk);
    start   = 1'b0;
    op      = 2'(~o);
    in_data = rnd_vec();
    repeat (LAT + 1) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    check(1'b0, "watchdog expired", DW'(cyc), DW'(0));
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    logic [DW-1:0] x, y, z, t, a, hold;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && out_data === '0, "R1 during reset", out_data, '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(done === 1'b0 && out_data === '0, "R1 after reset", out_data, '0);

    issue(2'd0, 0, rnd_vec(), "R3 pass a");
    issue(2'd0, 0, rnd_vec(), "R3 pass b");
    issue(2'd3, 0, rnd_vec(), "R3 alt pass");

    for (int s = 0; s < C; s++) issue(2'd1, s, rnd_vec(), "R4 broadcast");

    for (int k = 0; k < 3; k++) issue(2'd2, 0, rnd_vec(), "R5 grouping random");

    for (int e = 0; e < N; e++) x[e*W +: W] = W'(e);
    issue(2'd2, 0, x, "R2 R5 index pattern");
    for (int j = 0; j < N; j++) t[j*W +: W] = (j < C) ? W'(2*j) : W'(2*(j-C)+1);
    check(out_data === t, "R5 explicit even then odd", out_data, t);

    // R9: two grouping passes transpose a 2x4 row-major matrix
    x = rnd_vec();
    issue(2'd2, 0, x, "R9 pass 1");
    y = out_data;
    issue(2'd2, 0, y, "R9 pass 2");
    z = out_data;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 4; c++) t[(2*c + r)*W +: W] = x[(4*r + c)*W +: W];
    check(z === t, "R9 transpose", z, t);

    // R7: second start inside the busy window is ignored
    a = rnd_vec();
    @(negedge clk);
    start = 1'b1; op = 2'd2; src = 2'd0; in_data = a;
    exp_q.push_back(model(2'd2, 0, a));
    due_q.push_back(cyc + LAT + 1);
    tag_q.push_back("R7 running result");
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; op = 2'd1; src = 2'd3; in_data = rnd_vec();
    @(negedge clk);
    start = 1'b0;
    repeat (LAT + 6) @(negedge clk);

    // R8: output holds while inputs move and no start is given
    hold = out_data;
    for (int k = 0; k < 6; k++) begin
      in_data = rnd_vec();
      op = 2'(k);
      src = 2'(k);
      @(negedge clk);
    end
    check(out_data === hold, "R8 output hold", out_data, hold);

    check(exp_q.size() == 0, "R6 every completion seen", DW'(exp_q.size()), DW'(0));

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

endmodule